// File: doc/BRIEF.md
# Used-Ring Completion and Interrupt Notifier

This block retires finished request chains for a single shared-memory queue. For each completion it writes an eight-byte record into the used ring through a simple memory request port. The record holds the chain's head id and the byte count produced. A private next-used counter advances with each record, and the index the guest can see does not move. The guest learns of new entries only when a sync command is issued. A sync publishes the private counter into the ring's 16-bit index field and then decides whether to interrupt the guest.

The interrupt decision reads the flags word of the guest's available ring. An interrupt is raised when the guest has not asked for quiet. It is also raised when the notify-on-empty feature was negotiated and the queue has drained. A raised interrupt sets the queue cause bit in the interrupt status and drives the interrupt line. A skipped one is only counted. A third command sets or clears the device's no-notify hint in the used ring's flags word by read-modify-write. The payload itself is copied elsewhere.

The ring holds a power-of-two number of entries given by a parameter. Record addresses wrap modulo that depth, while the published index is a free-running 16-bit count.

Top module: `used_ring_notifier`

## Requirements
- R1: After reset, cmd_ready_o is 1, mem_req_o is 0, irq_o is 0, isr_o is 0, and both counters are 0. The private next-used index starts at 0.
- R2: A completion writes two 32-bit little-endian words. The id goes to used_base_i + 4 + 8*(n mod DEPTH), then the length goes to used_base_i + 8 + 8*(n mod DEPTH), where n is the private next-used index.
- R3: Each completion advances n by one, modulo 2^16, and leaves the 16-bit index field at used_base_i + 2 untouched.
- R4: A sync writes n as a 16-bit value to used_base_i + 2, then reads the 16-bit flags word at avail_base_i.
- R5: After that read, an interrupt is raised when flags bit 0 is 0, or when notify_on_empty_i and queue_empty_i are both 1. A raise sets isr_o bit 0 and irq_o, and adds one to irq_cnt_o.
- R6: When a sync raises no interrupt, skip_cnt_o gains one, and irq_o, isr_o and irq_cnt_o keep their values.
- R7: A pulse on isr_ack_i clears isr_o and lowers irq_o. If a raise occurs in the same cycle, the raise wins.
- R8: A notification command reads the 16-bit word at used_base_i and writes it back to the same address. Bit 0 is cleared when notif_enable_i is 1 and set when it is 0. Bits 15:1 are kept.
- R9: Commands are taken only while cmd_ready_o is 1. If several arrive in the same cycle, a completion beats a sync, and a sync beats a notification command. The losers are dropped, and commands presented while busy have no effect.
- R10: A memory request holds its address, direction and data until mem_ack_i. Results do not depend on the acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| used_base_i | input | ADDR_W | Byte address of the used ring |
| avail_base_i | input | ADDR_W | Byte address of the available ring flags word |
| notify_on_empty_i | input | 1 | Notify-on-empty feature negotiated |
| queue_empty_i | input | 1 | Available ring has no pending chains |
| cmpl_valid_i | input | 1 | Completion command |
| cmpl_id_i | input | 32 | Head id of the finished chain |
| cmpl_len_i | input | 32 | Bytes written into the chain |
| sync_i | input | 1 | Publish index and evaluate interrupt |
| notif_set_i | input | 1 | Update the no-notify hint |
| notif_enable_i | input | 1 | 1 enables notifications (clears hint), 0 disables |
| cmd_ready_o | output | 1 | Idle, a command is accepted this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_wide_o | output | 1 | 1 for 32-bit access, 0 for 16-bit |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 32 | Write data, 16-bit accesses use bits 15:0 |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |
| irq_o | output | 1 | Interrupt line |
| isr_o | output | ISR_W | Interrupt status, bit 0 is the queue cause |
| isr_ack_i | input | 1 | Clear interrupt status and line |
| irq_cnt_o | output | CNT_W | Interrupts raised |
| skip_cnt_o | output | CNT_W | Interrupts skipped |

## Verification
A completion finishes after two acknowledged writes. A sync finishes after one write and one read. A notification command finishes after one read and one write. In every case the private index, the interrupt line, the status and both counters update on the same edge where cmd_ready_o returns high. The bench therefore waits at falling edges for cmd_ready_o and checks memory contents and outputs at that falling edge, never at a fixed count. The same checks are repeated with a three-cycle acknowledge latency. For the same-cycle clear-and-raise case, the bench holds isr_ack_i until cmd_ready_o rises, so that the clear lands on the deciding edge.

// File: rtl/uring_pkg.sv
package uring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EL_ID,
    ST_EL_LEN,
    ST_PUB,
    ST_AFLG,
    ST_NF_RD,
    ST_NF_WR
  } uring_st_e;

  localparam int unsigned OFF_IDX    = 2;
  localparam int unsigned OFF_RING   = 4;
  localparam int unsigned ELEM_SHIFT = 3;
  localparam int unsigned IDX_W      = 16;
endpackage

// File: rtl/uring_cursor.sv
module uring_cursor
  import uring_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] used_base_i,
  output logic [IDX_W-1:0]  next_used_o,
  output logic [ADDR_W-1:0] slot_addr_o
);
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  nu_q;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    nu_q <= '0;
    else if (adv_i) nu_q <= nu_q + 1'b1;
  end

  assign slot        = nu_q[SLOT_W-1:0];
  assign next_used_o = nu_q;
  assign slot_addr_o = used_base_i + ADDR_W'(OFF_RING)
                     + (ADDR_W'(slot) << ELEM_SHIFT);

  AST_CURSOR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> next_used_o == $past(next_used_o) + 1'b1); // R3
  AST_CURSOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(next_used_o)); // R3
endmodule

// File: rtl/uring_irq.sv
module uring_irq #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ISR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             decide_i,
  input  logic             raise_i,
  input  logic             isr_ack_i,
  output logic             irq_o,
  output logic [ISR_W-1:0] isr_o,
  output logic [CNT_W-1:0] irq_cnt_o,
  output logic [CNT_W-1:0] skip_cnt_o
);
  localparam logic [ISR_W-1:0] CAUSE_Q = ISR_W'(1);

  logic fire, skip;
  assign fire = decide_i & raise_i;
  assign skip = decide_i & ~raise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      isr_o      <= '0;
      irq_cnt_o  <= '0;
      skip_cnt_o <= '0;
    end else begin
      if (fire) begin
        isr_o     <= (isr_ack_i ? '0 : isr_o) | CAUSE_Q;
        irq_o     <= 1'b1;
        irq_cnt_o <= irq_cnt_o + 1'b1;
      end else if (isr_ack_i) begin
        isr_o <= '0;
        irq_o <= 1'b0;
      end
      if (skip) skip_cnt_o <= skip_cnt_o + 1'b1;
    end
  end

  AST_RAISE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> irq_o && isr_o[0] && irq_cnt_o == $past(irq_cnt_o) + 1'b1); // R5
  AST_SKIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip |=> skip_cnt_o == $past(skip_cnt_o) + 1'b1 && $stable(irq_cnt_o)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_ack_i && !fire |=> !irq_o && isr_o == '0); // R7
  AST_LINE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> isr_o[0]); // R5
endmodule

// File: rtl/used_ring_notifier.sv
module used_ring_notifier
  import uring_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ISR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] used_base_i,
  input  logic [ADDR_W-1:0] avail_base_i,
  input  logic              notify_on_empty_i,
  input  logic              queue_empty_i,
  input  logic              cmpl_valid_i,
  input  logic [31:0]       cmpl_id_i,
  input  logic [31:0]       cmpl_len_i,
  input  logic              sync_i,
  input  logic              notif_set_i,
  input  logic              notif_enable_i,
  output logic              cmd_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              irq_o,
  output logic [ISR_W-1:0]  isr_o,
  input  logic              isr_ack_i,
  output logic [CNT_W-1:0]  irq_cnt_o,
  output logic [CNT_W-1:0]  skip_cnt_o
);
  uring_st_e         st_q, st_d;
  logic [31:0]       id_q, len_q;
  logic [15:0]       flags_q;
  logic              en_q;
  logic              adv, decide, raise;
  logic [IDX_W-1:0]  next_used;
  logic [ADDR_W-1:0] slot_addr;

  uring_cursor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cursor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .used_base_i (used_base_i),
    .next_used_o (next_used),
    .slot_addr_o (slot_addr)
  );

  uring_irq #(.CNT_W(CNT_W), .ISR_W(ISR_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .decide_i   (decide),
    .raise_i    (raise),
    .isr_ack_i  (isr_ack_i),
    .irq_o      (irq_o),
    .isr_o      (isr_o),
    .irq_cnt_o  (irq_cnt_o),
    .skip_cnt_o (skip_cnt_o)
  );

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign adv         = (st_q == ST_EL_LEN) & mem_ack_i;
  assign decide      = (st_q == ST_AFLG) & mem_ack_i;
  assign raise       = ~mem_rdata_i[0] | (notify_on_empty_i & queue_empty_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmpl_valid_i)     st_d = ST_EL_ID;
        else if (sync_i)      st_d = ST_PUB;
        else if (notif_set_i) st_d = ST_NF_RD;
      end
      ST_EL_ID:  if (mem_ack_i) st_d = ST_EL_LEN;
      ST_EL_LEN: if (mem_ack_i) st_d = ST_IDLE;
      ST_PUB:    if (mem_ack_i) st_d = ST_AFLG;
      ST_AFLG:   if (mem_ack_i) st_d = ST_IDLE;
      ST_NF_RD:  if (mem_ack_i) st_d = ST_NF_WR;
      ST_NF_WR:  if (mem_ack_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      id_q    <= '0;
      len_q   <= '0;
      en_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && cmpl_valid_i) begin
        id_q  <= cmpl_id_i;
        len_q <= cmpl_len_i;
      end
      if (st_q == ST_IDLE) en_q <= notif_enable_i;
      if (st_q == ST_NF_RD && mem_ack_i) flags_q <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_req_o   = (st_q != ST_IDLE);
    mem_we_o    = 1'b0;
    mem_wide_o  = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_EL_ID: begin
        mem_we_o    = 1'b1;
        mem_wide_o  = 1'b1;
        mem_addr_o  = slot_addr;
        mem_wdata_o = id_q;
      end
      ST_EL_LEN: begin
        mem_we_o    = 1'b1;
        mem_wide_o  = 1'b1;
        mem_addr_o  = slot_addr + ADDR_W'(4);
        mem_wdata_o = len_q;
      end
      ST_PUB: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = used_base_i + ADDR_W'(OFF_IDX);
        mem_wdata_o = {16'h0, next_used};
      end
      ST_AFLG:  mem_addr_o = avail_base_i;
      ST_NF_RD: mem_addr_o = used_base_i;
      ST_NF_WR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = used_base_i;
        mem_wdata_o = {16'h0, flags_q[15:1], ~en_q};
      end
      default: ;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o && !mem_ack_i |=> !cmd_ready_o); // R9
  AST_PUB_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PUB && mem_ack_i |=> mem_req_o && !mem_we_o
      && mem_addr_o == avail_base_i); // R4
endmodule

// File: tb/tb_used_ring_notifier.sv
module tb_used_ring_notifier;
  localparam int DEPTH = 4;
  localparam int CNT_W = 8;
  localparam logic [31:0] UBASE = 32'h100;
  localparam logic [31:0] ABASE = 32'h040;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic noe = 1'b0, qempty = 1'b0;
  logic cmpl_valid = 1'b0, sync = 1'b0, nset = 1'b0, nen = 1'b0, isr_ack = 1'b0;
  logic [31:0] cid = '0, clen = '0;
  logic cmd_ready, mem_req, mem_we, mem_wide, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic [7:0] isr;
  logic [CNT_W-1:0] irq_cnt, skip_cnt;

  logic [7:0] mem [0:511];
  int lat = 0, wait_q = 0;
  logic poke_req = 1'b0;
  logic [8:0] poke_addr = '0;
  logic [15:0] poke_val = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  used_ring_notifier #(.DEPTH(DEPTH), .ADDR_W(32), .CNT_W(CNT_W), .ISR_W(8)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .used_base_i(UBASE), .avail_base_i(ABASE),
    .notify_on_empty_i(noe), .queue_empty_i(qempty),
    .cmpl_valid_i(cmpl_valid), .cmpl_id_i(cid), .cmpl_len_i(clen),
    .sync_i(sync), .notif_set_i(nset), .notif_enable_i(nen),
    .cmd_ready_o(cmd_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_wide_o(mem_wide), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .irq_o(irq), .isr_o(isr), .isr_ack_i(isr_ack),
    .irq_cnt_o(irq_cnt), .skip_cnt_o(skip_cnt)
  );

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h0;
  end

  always @(negedge clk_i) begin
    if (poke_req) begin
      mem[poke_addr]      <= poke_val[7:0];
      mem[poke_addr + 1]  <= poke_val[15:8];
    end
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_q < lat) wait_q <= wait_q + 1;
      else begin
        wait_q  <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[8:0]]     <= mem_wdata[7:0];
          mem[mem_addr[8:0] + 1] <= mem_wdata[15:8];
          if (mem_wide) begin
            mem[mem_addr[8:0] + 2] <= mem_wdata[23:16];
            mem[mem_addr[8:0] + 3] <= mem_wdata[31:24];
          end
        end else mem_rdata <= {mem[mem_addr[8:0] + 1], mem[mem_addr[8:0]]};
      end
    end
  end

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {mem[a[8:0] + 1], mem[a[8:0]]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[a[8:0] + 3], mem[a[8:0] + 2], mem[a[8:0] + 1], mem[a[8:0]]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke16(input logic [31:0] a, input logic [15:0] v);
    poke_addr = a[8:0];
    poke_val  = v;
    poke_req  = 1'b1;
    @(posedge clk_i); @(negedge clk_i); @(posedge clk_i);
    poke_req = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk_i);
  endtask

  task automatic do_cmpl(input logic [31:0] id, input logic [31:0] len);
    cid = id; clen = len; cmpl_valid = 1'b1;
    @(negedge clk_i); cmpl_valid = 1'b0;
    wait_ready();
  endtask

  task automatic do_sync();
    sync = 1'b1;
    @(negedge clk_i); sync = 1'b0;
    wait_ready();
  endtask

  task automatic do_notif(input logic en);
    nen = en; nset = 1'b1;
    @(negedge clk_i); nset = 1'b0;
    wait_ready();
  endtask

  task automatic clear_isr();
    isr_ack = 1'b1;
    @(negedge clk_i); isr_ack = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk_i); cyc++; end
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int nu = 0, exp_irq = 0, exp_skip = 0;
    logic [31:0] sa;
    logic raise;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 ready", {31'b0, cmd_ready}, 1);
    check("R1 req",   {31'b0, mem_req}, 0);
    check("R1 irq",   {31'b0, irq}, 0);
    check("R1 isr",   {24'b0, isr}, 0);
    check("R1 cnts",  {16'b0, irq_cnt, skip_cnt}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    poke16(UBASE + 2, 16'hBEEF);

    // R2 R3 completions across two ring wraps
    for (int i = 0; i < 10; i++) begin
      do_cmpl(32'h1000 + i * 32'h11, 32'h200 + i);
      sa = UBASE + 4 + 8 * (nu % DEPTH);
      check("R2 id",  rd32(sa), 32'h1000 + i * 32'h11);
      check("R2 len", rd32(sa + 4), 32'h200 + i);
      check("R3 idx untouched", {16'b0, rd16(UBASE + 2)}, 32'hBEEF);
      nu++;
    end

    // R4 R5 R6 R7 all flag/feature/empty combinations
    for (int c = 0; c < 8; c++) begin
      poke16(ABASE, 16'hA5A4 | 16'(c & 1));
      noe = c[1]; qempty = c[2];
      do_sync();
      raise = !c[0] || (c[1] && c[2]);
      if (raise) exp_irq++; else exp_skip++;
      check("R4 publish", {16'b0, rd16(UBASE + 2)}, nu);
      check("R5 irq_cnt",  {24'b0, irq_cnt}, exp_irq);
      check("R6 skip_cnt", {24'b0, skip_cnt}, exp_skip);
      check("R5 line",     {31'b0, irq}, {31'b0, raise});
      check("R5 isr",      {24'b0, isr}, {31'b0, raise});
      clear_isr();
      check("R7 cleared", {23'b0, irq, isr}, 0);
      do_cmpl(32'hC0 + c, 32'h40);
      nu++;
    end

    // R7 raise and clear on the same edge: raise wins
    poke16(ABASE, 16'h0000);
    isr_ack = 1'b1;
    sync = 1'b1;
    @(negedge clk_i); sync = 1'b0;
    wait_ready();
    isr_ack = 1'b0;
    exp_irq++;
    check("R7 raise wins line", {31'b0, irq}, 1);
    check("R7 raise wins isr",  {24'b0, isr}, 1);
    clear_isr();

    // R8 notification hint
    poke16(UBASE, 16'hC3C2);
    do_notif(1'b0);
    check("R8 disable sets bit0", {16'b0, rd16(UBASE)}, 32'hC3C3);
    do_notif(1'b1);
    check("R8 enable clears bit0", {16'b0, rd16(UBASE)}, 32'hC3C2);
    poke16(UBASE, 16'h0001);
    do_notif(1'b1);
    check("R8 enable from set", {16'b0, rd16(UBASE)}, 0);
    check("R8 no irq effect", {16'b0, irq_cnt, skip_cnt}, {16'b0, 8'(exp_irq), 8'(exp_skip)});

    // R9 priority among simultaneous commands
    poke16(UBASE + 2, 16'hBEEF);
    poke16(UBASE, 16'h5550);
    poke16(ABASE, 16'h0000);
    cid = 32'hAAAA0001; clen = 32'h77; cmpl_valid = 1'b1; sync = 1'b1; nset = 1'b1; nen = 1'b0;
    @(negedge clk_i); cmpl_valid = 1'b0; sync = 1'b0; nset = 1'b0;
    wait_ready();
    repeat (4) @(negedge clk_i);
    sa = UBASE + 4 + 8 * (nu % DEPTH);
    check("R9 completion wins", rd32(sa), 32'hAAAA0001);
    check("R9 sync dropped", {16'b0, rd16(UBASE + 2)}, 32'hBEEF);
    check("R9 notif dropped", {16'b0, rd16(UBASE)}, 32'h5550);
    nu++;
    // R9 commands while busy are ignored
    cid = 32'hAAAA0002; cmpl_valid = 1'b1;
    @(negedge clk_i); cmpl_valid = 1'b0; sync = 1'b1;
    @(negedge clk_i); sync = 1'b0;
    wait_ready();
    repeat (4) @(negedge clk_i);
    nu++;
    check("R9 busy sync idx", {16'b0, rd16(UBASE + 2)}, 32'hBEEF);
    check("R9 busy sync cnt", {16'b0, irq_cnt, skip_cnt}, {16'b0, 8'(exp_irq), 8'(exp_skip)});

    // R10 slow acknowledge
    lat = 3;
    do_cmpl(32'hDEAD0010, 32'h1234);
    sa = UBASE + 4 + 8 * (nu % DEPTH);
    check("R10 id slow",  rd32(sa), 32'hDEAD0010);
    check("R10 len slow", rd32(sa + 4), 32'h1234);
    nu++;
    poke16(ABASE, 16'h0001);
    noe = 1'b1; qempty = 1'b1;
    do_sync();
    exp_irq++;
    check("R10 publish slow", {16'b0, rd16(UBASE + 2)}, nu);
    check("R10 irq slow", {24'b0, irq_cnt}, exp_irq);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule